// File: doc/BRIEF.md
# Locked Read-Modify-Write Line Gate

The gate stands between a processor's memory request port and a first-level cache controller. Its job is to keep a locked read-modify-write sequence atomic. When the controller reports that a locked-read has completed, the gate records the cache line of that access as locked. From then on, any request that targets the same line is refused, unless it is the matching locked-write. The gate keeps refusing such requests until a completed locked-write releases the line.

A refused request is not forwarded. It comes back to the requester with an aliased status, and the requester may retry it later. Requests to any other line go through unchanged. Lock state is kept per 64-byte line in a small fully associative table. A global blocking-enable input decides whether held locks are enforced at all. A completion that would need a fifth table slot sets a sticky overflow flag.

Top module: `rmw_line_gate`

## Requirements
- R1: Synchronous active-high reset clears every lock and the overflow flag, and drives `fwd_valid` and `rsp_valid` low. A load to a line that was locked before reset is forwarded afterwards.
- R2: An accepted request to an unlocked line is forwarded on the clock edge after the handshake. `fwd_valid` is high for that one cycle, `fwd_addr` and `fwd_type` equal the request, and `rsp_valid` is high with `rsp_status` = 0 (accepted).
- R3: While a line is locked, a load (type 0), store (type 1) or instruction fetch (type 2) to that line is not forwarded. It is answered with `rsp_status` = 1 (aliased) one edge after the handshake.
- R4: Lines are compared on address bits [31:6], and bits [5:0] are ignored. Any byte inside a locked line is refused. Another line is forwarded, including in the cycle in which a lock is set.
- R5: A locked-write request (type 4) to a locked line is forwarded with status 0.
- R6: A completion of type 4 on `cpl_*` clears the lock on its line. Later requests to that line are forwarded.
- R7: While `block_en` is low, no request is refused, even to a line held in the table.
- R8: A locked-read completion (type 3) on `cpl_*` in the same cycle as a request to the same line makes that request see the new lock, so it is refused.
- R9: A locked-read completion for a new line while all 4 table entries are valid sets `ovf_err`. The flag stays high until reset, and the new line is not locked.
- R10: A locked-read request (type 3) to a locked line is refused like any other type that is not a locked-write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| block_en | input | 1 | Global enable for lock enforcement |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Gate can take a request (low during reset) |
| req_addr | input | 32 | Request byte address |
| req_type | input | 3 | 0 load, 1 store, 2 ifetch, 3 locked-read, 4 locked-write |
| cpl_valid | input | 1 | Controller completion strobe |
| cpl_addr | input | 32 | Completed access byte address |
| cpl_type | input | 3 | Completed access type, same encoding |
| fwd_valid | output | 1 | One-cycle strobe of a forwarded request |
| fwd_addr | output | 32 | Forwarded address |
| fwd_type | output | 3 | Forwarded type |
| rsp_valid | output | 1 | Status of the previous cycle's request is valid |
| rsp_status | output | 2 | 0 accepted, 1 aliased |
| ovf_err | output | 1 | Sticky lock-table overflow |

## Verification
The forward strobe, the forwarded fields and the response status all appear on the first rising edge after the handshake. A lock set or cleared by a completion takes effect for requests one edge later, with one exception: a request in the same cycle as a locked-read completion sees that lock at once. The overflow flag rises on the edge that takes the offending completion. The bench changes inputs on the falling edge, so each vector is held for exactly one cycle, and it samples all outputs on the following falling edge. Each check therefore sees the result of exactly one rising edge.

// File: rtl/rmw_gate_pkg.sv
package rmw_gate_pkg;
   typedef enum logic [2:0] {
      RK_LOAD  = 3'd0,
      RK_STORE = 3'd1,
      RK_FETCH = 3'd2,
      RK_LRD   = 3'd3,
      RK_LWR   = 3'd4
   } req_kind_e;

   typedef enum logic [1:0] {
      ST_PASS  = 2'd0,
      ST_ALIAS = 2'd1
   } rsp_code_e;
endpackage

// File: rtl/rmw_lock_table.sv
module rmw_lock_table #(
   parameter int LINE_W  = 26,
   parameter int ENTRIES = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [LINE_W-1:0] look_line,
   output logic              look_hit,
   input  logic [LINE_W-1:0] upd_line,
   input  logic              upd_set,
   input  logic              upd_clr,
   output logic              ovf_flag
);
   logic [ENTRIES-1:0] vld;
   logic [LINE_W-1:0]  tag [ENTRIES];
   logic [ENTRIES-1:0] look_m;
   logic [ENTRIES-1:0] upd_m;
   logic [ENTRIES-1:0] free_oh;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign look_m[i] = vld[i] && (tag[i] == look_line);
      assign upd_m[i]  = vld[i] && (tag[i] == upd_line);
   end

   assign look_hit = |look_m;

   if (ENTRIES == 1) begin : g_free_single
      assign free_oh = ~vld;
   end else begin : g_free_scan
      always_comb begin
         logic taken;
         taken   = 1'b0;
         free_oh = '0;
         for (int i = 0; i < ENTRIES; i++) begin
            if (!vld[i] && !taken) begin
               free_oh[i] = 1'b1;
               taken      = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld      <= '0;
         ovf_flag <= 1'b0;
      end else if (upd_set && (upd_m == '0)) begin
         if (free_oh == '0) begin
            ovf_flag <= 1'b1;
         end else begin
            for (int i = 0; i < ENTRIES; i++) begin
               if (free_oh[i]) begin
                  vld[i] <= 1'b1;
                  tag[i] <= upd_line;
               end
            end
         end
      end else if (upd_clr) begin
         vld <= vld & ~upd_m;
      end
   end
endmodule

// File: rtl/rmw_admit.sv
module rmw_admit
   import rmw_gate_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LINE_W = 26
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_type,
   input  logic [LINE_W-1:0] req_line,
   input  logic              block_en,
   input  logic              tbl_hit,
   input  logic              cpl_lrd,
   input  logic [LINE_W-1:0] cpl_line,
   output logic              fwd_valid,
   output logic [ADDR_W-1:0] fwd_addr,
   output logic [2:0]        fwd_type,
   output logic              rsp_valid,
   output logic [1:0]        rsp_status
);
   logic line_locked;
   logic refuse;

   // a lock being set this cycle is visible to a request this cycle
   assign line_locked = tbl_hit || (cpl_lrd && (cpl_line == req_line));
   assign refuse      = block_en && line_locked && (req_type != RK_LWR);

   always_ff @(posedge clk) begin
      if (rst) begin
         fwd_valid  <= 1'b0;
         rsp_valid  <= 1'b0;
         rsp_status <= ST_PASS;
      end else begin
         fwd_valid  <= accept && !refuse;
         rsp_valid  <= accept;
         rsp_status <= (accept && refuse) ? ST_ALIAS : ST_PASS;
      end
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         fwd_addr <= req_addr;
         fwd_type <= req_type;
      end
   end
endmodule

// File: rtl/rmw_line_gate.sv
module rmw_line_gate
   import rmw_gate_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LINE_OFFS = 6,
   parameter int LOCK_ENTRIES = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              block_en,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_type,
   input  logic              cpl_valid,
   input  logic [ADDR_W-1:0] cpl_addr,
   input  logic [2:0]        cpl_type,
   output logic              fwd_valid,
   output logic [ADDR_W-1:0] fwd_addr,
   output logic [2:0]        fwd_type,
   output logic              rsp_valid,
   output logic [1:0]        rsp_status,
   output logic              ovf_err
);
   localparam int LINE_W = ADDR_W - LINE_OFFS;

   if (LINE_OFFS < 0 || LINE_OFFS >= ADDR_W) begin : g_bad_offs
      $error("rmw_line_gate: LINE_OFFS must lie in [0, ADDR_W)");
   end
   if (LOCK_ENTRIES < 1) begin : g_bad_depth
      $error("rmw_line_gate: LOCK_ENTRIES must be at least 1");
   end

   logic [LINE_W-1:0] req_line;
   logic [LINE_W-1:0] cpl_line;
   logic              accept;
   logic              cpl_lrd;
   logic              cpl_lwr;
   logic              tbl_hit;
   logic              unused_low;

   assign req_line   = req_addr[ADDR_W-1:LINE_OFFS];
   assign cpl_line   = cpl_addr[ADDR_W-1:LINE_OFFS];
   assign unused_low = ^cpl_addr;
   assign req_ready  = !rst;
   assign accept     = req_valid && req_ready;
   assign cpl_lrd    = cpl_valid && (cpl_type == RK_LRD);
   assign cpl_lwr    = cpl_valid && (cpl_type == RK_LWR);

   rmw_lock_table #(
      .LINE_W  (LINE_W),
      .ENTRIES (LOCK_ENTRIES)
   ) u_table (
      .clk       (clk),
      .rst       (rst),
      .look_line (req_line),
      .look_hit  (tbl_hit),
      .upd_line  (cpl_line),
      .upd_set   (cpl_lrd),
      .upd_clr   (cpl_lwr),
      .ovf_flag  (ovf_err)
   );

   rmw_admit #(
      .ADDR_W (ADDR_W),
      .LINE_W (LINE_W)
   ) u_admit (
      .clk        (clk),
      .rst        (rst),
      .accept     (accept),
      .req_addr   (req_addr),
      .req_type   (req_type),
      .req_line   (req_line),
      .block_en   (block_en),
      .tbl_hit    (tbl_hit),
      .cpl_lrd    (cpl_lrd),
      .cpl_line   (cpl_line),
      .fwd_valid  (fwd_valid),
      .fwd_addr   (fwd_addr),
      .fwd_type   (fwd_type),
      .rsp_valid  (rsp_valid),
      .rsp_status (rsp_status)
   );
endmodule

// File: rtl/rmw_gate_chk.sv
module rmw_gate_chk
   import rmw_gate_pkg::*;
(
   input logic       clk,
   input logic       rst,
   input logic       block_en,
   input logic       req_valid,
   input logic       req_ready,
   input logic [2:0] req_type,
   input logic       fwd_valid,
   input logic       rsp_valid,
   input logic [1:0] rsp_status,
   input logic       ovf_err
);
   // R2
   fwd_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
      fwd_valid |-> $past(req_valid && req_ready));
   // R2
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready) |=> rsp_valid);
   // R3
   alias_not_fwd_chk: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && rsp_status == ST_ALIAS) |-> !fwd_valid);
   // R5
   lwr_always_fwd_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready && req_type == RK_LWR) |=> fwd_valid);
   // R7
   gate_off_fwd_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready && !block_en) |=> fwd_valid);
   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      ovf_err |=> ovf_err);
   // R1
   status_code_chk: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> (rsp_status == ST_PASS || rsp_status == ST_ALIAS));
endmodule

bind rmw_line_gate rmw_gate_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .block_en   (block_en),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_type   (req_type),
   .fwd_valid  (fwd_valid),
   .rsp_valid  (rsp_valid),
   .rsp_status (rsp_status),
   .ovf_err    (ovf_err)
);

// File: tb/test_rmw_line_gate.sv
module test_rmw_line_gate;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        block_en = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [2:0]  req_type = '0;
   logic        cpl_valid = 1'b0;
   logic [31:0] cpl_addr = '0;
   logic [2:0]  cpl_type = '0;
   logic        fwd_valid;
   logic [31:0] fwd_addr;
   logic [2:0]  fwd_type;
   logic        rsp_valid;
   logic [1:0]  rsp_status;
   logic        ovf_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   rmw_line_gate i_rmw_line_gate (
      .clk(clk), .rst(rst), .block_en(block_en),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_type(req_type),
      .cpl_valid(cpl_valid), .cpl_addr(cpl_addr), .cpl_type(cpl_type),
      .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_type(fwd_type),
      .rsp_valid(rsp_valid), .rsp_status(rsp_status), .ovf_err(ovf_err)
   );

   typedef struct packed {
      logic [3:0]  rq;
      logic        cv;
      logic [2:0]  ct;
      logic [31:0] ca;
      logic        rv;
      logic [2:0]  rt;
      logic [31:0] ra;
      logic        be;
      logic        xr;
      logic        xf;
      logic [1:0]  xs;
   } vec_t;

   localparam logic [31:0] LA = 32'h1000_0040;
   localparam logic [31:0] LB = 32'h1000_0080;

   // rows: R2, R4, R3 x3, R10, R7, R5, R6 setup, R6, R8, R6 setup, R6
   localparam vec_t VECS [13] = '{
      '{4'd2,  1'b0, 3'd0, 32'h0,     1'b1, 3'd0, LA + 32'h4,  1'b1, 1'b1, 1'b1, 2'd0},
      '{4'd4,  1'b1, 3'd3, LA,        1'b1, 3'd1, LB,          1'b1, 1'b1, 1'b1, 2'd0},
      '{4'd3,  1'b0, 3'd0, 32'h0,     1'b1, 3'd0, LA + 32'h3C, 1'b1, 1'b1, 1'b0, 2'd1},
      '{4'd3,  1'b0, 3'd0, 32'h0,     1'b1, 3'd1, LA,          1'b1, 1'b1, 1'b0, 2'd1},
      '{4'd3,  1'b0, 3'd0, 32'h0,     1'b1, 3'd2, LA + 32'h1,  1'b1, 1'b1, 1'b0, 2'd1},
      '{4'd10, 1'b0, 3'd0, 32'h0,     1'b1, 3'd3, LA,          1'b1, 1'b1, 1'b0, 2'd1},
      '{4'd7,  1'b0, 3'd0, 32'h0,     1'b1, 3'd0, LA,          1'b0, 1'b1, 1'b1, 2'd0},
      '{4'd5,  1'b0, 3'd0, 32'h0,     1'b1, 3'd4, LA,          1'b1, 1'b1, 1'b1, 2'd0},
      '{4'd6,  1'b1, 3'd4, LA + 32'h10, 1'b1, 3'd0, LB,        1'b1, 1'b1, 1'b1, 2'd0},
      '{4'd6,  1'b0, 3'd0, 32'h0,     1'b1, 3'd0, LA,          1'b1, 1'b1, 1'b1, 2'd0},
      '{4'd8,  1'b1, 3'd3, LB,        1'b1, 3'd0, LB + 32'h8,  1'b1, 1'b1, 1'b0, 2'd1},
      '{4'd6,  1'b1, 3'd4, LB,        1'b0, 3'd0, 32'h0,       1'b1, 1'b0, 1'b0, 2'd0},
      '{4'd6,  1'b0, 3'd0, 32'h0,     1'b1, 3'd0, LB,          1'b1, 1'b1, 1'b1, 2'd0}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic cv, input logic [2:0] ct, input logic [31:0] ca,
                        input logic rv, input logic [2:0] rt, input logic [31:0] ra,
                        input logic be);
      cpl_valid = cv; cpl_type = ct; cpl_addr = ca;
      req_valid = rv; req_type = rt; req_addr = ra; block_en = be;
   endtask

   task automatic idle();
      drive(1'b0, 3'd0, 32'h0, 1'b0, 3'd0, 32'h0, 1'b1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk("R1", "fwd_valid", 32'(fwd_valid), 32'd0);
      chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
      chk("R1", "ovf_err",   32'(ovf_err),   32'd0);
      chk("R1", "req_ready", 32'(req_ready), 32'd1);

      for (int r = 0; r < 13; r++) begin
         vec_t v;
         string tag;
         v = VECS[r];
         tag = $sformatf("R%0d", v.rq);
         drive(v.cv, v.ct, v.ca, v.rv, v.rt, v.ra, v.be);
         @(negedge clk);
         chk(tag, "rsp_valid", 32'(rsp_valid), 32'(v.xr));
         chk(tag, "fwd_valid", 32'(fwd_valid), 32'(v.xf));
         if (v.xr) chk(tag, "rsp_status", 32'(rsp_status), 32'(v.xs));
         if (v.xf) begin
            chk(tag, "fwd_addr", fwd_addr, v.ra);
            chk(tag, "fwd_type", 32'(fwd_type), 32'(v.rt));
         end
      end
      idle();
      @(negedge clk);
      chk("R2", "fwd one cycle", 32'(fwd_valid), 32'd0);

      // R9 fill four entries, then one more line
      for (int i = 0; i < 4; i++) begin
         drive(1'b1, 3'd3, 32'h2000_0000 + 32'(i) * 32'd64, 1'b0, 3'd0, 32'h0, 1'b1);
         @(negedge clk);
      end
      chk("R9", "ovf_err full", 32'(ovf_err), 32'd0);
      drive(1'b1, 3'd3, 32'h2000_0100, 1'b0, 3'd0, 32'h0, 1'b1);
      @(negedge clk);
      chk("R9", "ovf_err set", 32'(ovf_err), 32'd1);
      drive(1'b0, 3'd0, 32'h0, 1'b1, 3'd0, 32'h2000_0100, 1'b1);
      @(negedge clk);
      chk("R9", "dropped line fwd", 32'(fwd_valid), 32'd1);
      drive(1'b0, 3'd0, 32'h0, 1'b1, 3'd1, 32'h2000_0008, 1'b1);
      @(negedge clk);
      chk("R9", "held line status", 32'(rsp_status), 32'd1);
      chk("R9", "ovf_err sticky", 32'(ovf_err), 32'd1);

      // R1 reset clears locks and overflow
      idle();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      chk("R1", "ovf_err cleared", 32'(ovf_err), 32'd0);
      drive(1'b0, 3'd0, 32'h0, 1'b1, 3'd0, 32'h2000_0000, 1'b1);
      @(negedge clk);
      chk("R1", "lock cleared fwd", 32'(fwd_valid), 32'd1);
      chk("R1", "lock cleared status", 32'(rsp_status), 32'd0);
      idle();
      @(negedge clk);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule